// File: doc/BRIEF.md
# Configurable I/O Port Bank

This block is a bank of four 8-bit I/O ports, named A, B, C and D. A microcontroller sets each pin through small configuration registers using ordinary bus reads and writes. Each pin can be set on its own to general I/O or to address output, to input or output, and to push-pull or open-drain drive. On ports whose drive bit selects edge rate instead, that bit chooses slow or fast slew. For each pin the block computes the value to drive, an output enable, an open-drain flag and a fast-slew flag, which feed the pad cells.

A pin is an output when its direction bit is set or when an external output-enable term from a logic array is active. Ports A, B and C accept that term, and port D does not. Only ports A and B have the mode register, which switches a pin between the MCU data-out register and an external address bit. Port D has three pins.

The bus address is 5 bits. Bits [4:2] pick the register kind: 0 is mode, 1 is direction, 2 is drive, 3 is data-out and 4 is data-in (read-only). Bits [1:0] pick the port, with A=0 up to D=3. Pin i of port p sits on bit p*8+i of every pad-side bus.

Top module: `cfg_io_bank`

## Requirements
- R1: After reset, every register reads 00h, and no pad output enable, open-drain flag or fast flag is set.
- R2: A write with `bus_wr` high takes effect at the next rising clock edge. `bus_rdata` shows the addressed register combinationally in the same cycle as the address.
- R3: Register bit i of a port controls only pin i of that port.
- R4: On ports A and B, a mode bit of 1 drives the pin from the matching bit of `ext_addr`. A mode bit of 0 drives it from the data-out register.
- R5: On ports C and D, the mode register reads 00h, writes to it are ignored, and `ext_addr` never reaches the pad.
- R6: When no product term is active, a direction bit of 1 enables the pin as an output and a direction bit of 0 leaves it as an input.
- R7: On ports A, B and C, an active `pt_oe` bit enables the pin as an output whatever the direction bit holds.
- R8: Port D ignores `pt_oe`. Its direction register alone sets its direction.
- R9: Port D implements only bits [2:0]. Its upper register bits read 0, and its upper pad bits stay 0.
- R10: On ports A and B, a drive bit of 1 makes the pin open drain. The enable is asserted only while the data bit is 0, `pad_out` is 0, and `pad_od` is set.
- R11: On ports C and D, a drive bit of 1 selects fast slew on `pad_fast`, and `pad_od` stays 0.
- R12: The data-in register returns `pad_in` for the port in every mode. Unimplemented port D bits read 0.
- R13: Addresses with a kind code above 4 read 0, and writes to them or to data-in change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Register address: kind in [4:2], port in [1:0] |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| pad_in | input | 32 | Pin input levels |
| ext_addr | input | 32 | Address bits for address-output mode |
| pt_oe | input | 32 | Output-enable terms from the logic array |
| pad_out | output | 32 | Value driven on each pin |
| pad_oe | output | 32 | Output enable for each pin |
| pad_od | output | 32 | Open-drain flag for each pin |
| pad_fast | output | 32 | Fast-slew flag for each pin |

## Verification
The bench checks that open-drain pins release on a 1. A design that treated open drain as plain push-pull would leave the enable high on those bits. It drives `pt_oe` on port D with the direction bits cleared, so a design that merged the term there would show port D enables. It writes all ones to the port C mode register and to port D's upper bits, and reads them back together with the pads, so that stray flops or leaking address bits show up as nonzero values. Writes to unmapped and read-only addresses are followed by readbacks, which catch any decode that aliases into a real register.

// File: rtl/cfg_io_pkg.sv
package cfg_io_pkg;
  localparam int NPORT  = 4;
  localparam int NKIND  = 5;
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    K_MODE = 3'd0,
    K_DIR  = 3'd1,
    K_DRV  = 3'd2,
    K_DOUT = 3'd3,
    K_DIN  = 3'd4
  } reg_kind_e;
endpackage

// File: rtl/cfg_io_decode.sv
module cfg_io_decode
  import cfg_io_pkg::*;
(
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr,
  output reg_kind_e              kind,
  output logic [1:0]             port,
  output logic                   hit,
  output logic [NKIND*NPORT-1:0] wr_sel
);
  logic [2:0] kind_raw;

  assign kind_raw = addr[4:2];
  assign port     = addr[1:0];
  assign hit      = (kind_raw < 3'(NKIND));
  assign kind     = reg_kind_e'(kind_raw);

  // data-in (kind 4) is read-only: no write select is produced for it
  always_comb begin
    wr_sel = '0;
    for (int k = 0; k < NKIND; k++) begin
      for (int p = 0; p < NPORT; p++) begin
        wr_sel[k*NPORT+p] = wr && hit && (kind_raw == 3'(k)) &&
                            (port == 2'(p)) && (k != int'(K_DIN));
      end
    end
  end
endmodule

// File: rtl/cfg_io_port_regs.sv
module cfg_io_port_regs #(
  parameter int               PIN_W    = 8,
  parameter logic [PIN_W-1:0] PIN_MASK = '1,
  parameter bit               HAS_MODE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] wdata,
  input  logic             wr_mode,
  input  logic             wr_dir,
  input  logic             wr_drv,
  input  logic             wr_dout,
  output logic [PIN_W-1:0] mode_q,
  output logic [PIN_W-1:0] dir_q,
  output logic [PIN_W-1:0] drv_q,
  output logic [PIN_W-1:0] dout_q
);
  localparam logic [PIN_W-1:0] MODE_MASK = HAS_MODE ? PIN_MASK : '0;

  logic [PIN_W-1:0] wmasked;
  assign wmasked = wdata & PIN_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      drv_q  <= '0;
      dout_q <= '0;
    end else begin
      if (wr_mode) mode_q <= wdata & MODE_MASK;
      if (wr_dir)  dir_q  <= wmasked;
      if (wr_drv)  drv_q  <= wmasked;
      if (wr_dout) dout_q <= wmasked;
    end
  end

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata & PIN_MASK));

  // R2
  dout_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dout |=> dout_q == $past(wdata & PIN_MASK));

  // R5
  mode_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    HAS_MODE || (mode_q == '0));
endmodule

// File: rtl/cfg_io_pin_path.sv
module cfg_io_pin_path #(
  parameter int               PIN_W    = 8,
  parameter logic [PIN_W-1:0] PIN_MASK = '1,
  parameter bit               HAS_PT   = 1'b1,
  parameter bit               SLEW_DRV = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] mode_q,
  input  logic [PIN_W-1:0] dir_q,
  input  logic [PIN_W-1:0] drv_q,
  input  logic [PIN_W-1:0] dout_q,
  input  logic [PIN_W-1:0] ext_addr,
  input  logic [PIN_W-1:0] pt_oe,
  output logic [PIN_W-1:0] pad_out,
  output logic [PIN_W-1:0] pad_oe,
  output logic [PIN_W-1:0] pad_od,
  output logic [PIN_W-1:0] pad_fast
);
  function automatic logic [PIN_W-1:0] pick_src(
    input logic [PIN_W-1:0] mode, input logic [PIN_W-1:0] ext,
    input logic [PIN_W-1:0] dout);
    return (mode & ext) | (~mode & dout);
  endfunction

  function automatic logic [PIN_W-1:0] pin_enable(
    input logic [PIN_W-1:0] dir, input logic [PIN_W-1:0] pt,
    input logic [PIN_W-1:0] od, input logic [PIN_W-1:0] src);
    return (dir | pt) & ~(od & src);
  endfunction

  logic [PIN_W-1:0] data_src;
  logic [PIN_W-1:0] pt_eff;
  logic [PIN_W-1:0] od_sel;
  logic [PIN_W-1:0] od_release;

  assign data_src   = pick_src(mode_q, ext_addr, dout_q);
  assign pt_eff     = HAS_PT ? pt_oe : '0;
  assign od_sel     = SLEW_DRV ? '0 : drv_q;
  assign od_release = od_sel & data_src;

  assign pad_out  = data_src & ~od_sel & PIN_MASK;
  assign pad_oe   = pin_enable(dir_q, pt_eff, od_sel, data_src) & PIN_MASK;
  assign pad_od   = od_sel & PIN_MASK;
  assign pad_fast = (SLEW_DRV ? drv_q : '0) & PIN_MASK;

  // R10
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & od_release) == '0) && ((pad_out & pad_od) == '0));

  // R7
  pt_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_PT || ((pt_oe & PIN_MASK & ~od_release & ~pad_oe) == '0));

  // R6
  dir_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q & ~od_release & ~pad_oe) == '0));

  // R4
  addr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q & ~pad_od & (pad_out ^ ext_addr)) == '0));

  // R11
  slew_no_od_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !SLEW_DRV || (pad_od == '0));
endmodule

// File: rtl/cfg_io_bank.sv
module cfg_io_bank
  import cfg_io_pkg::*;
#(
  parameter int               PIN_W      = 8,
  parameter int               NARROW_W   = 3,
  parameter int               NARROW_P   = 3,
  parameter logic [NPORT-1:0] MODE_PORTS = 4'b0011,
  parameter logic [NPORT-1:0] PT_PORTS   = 4'b0111,
  parameter logic [NPORT-1:0] SLEW_PORTS = 4'b1100
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic [PIN_W-1:0]       bus_wdata,
  output logic [PIN_W-1:0]       bus_rdata,
  input  logic [NPORT*PIN_W-1:0] pad_in,
  input  logic [NPORT*PIN_W-1:0] ext_addr,
  input  logic [NPORT*PIN_W-1:0] pt_oe,
  output logic [NPORT*PIN_W-1:0] pad_out,
  output logic [NPORT*PIN_W-1:0] pad_oe,
  output logic [NPORT*PIN_W-1:0] pad_od,
  output logic [NPORT*PIN_W-1:0] pad_fast
);
  function automatic logic [PIN_W-1:0] lane_width_mask(input int p);
    logic [PIN_W-1:0] m;
    m = '1;
    if (p == NARROW_P) m = (PIN_W)'((1 << NARROW_W) - 1);
    return m;
  endfunction

  reg_kind_e                   kind;
  logic [1:0]                  port;
  logic                        hit;
  logic [NKIND*NPORT-1:0]      wr_sel;
  logic [NPORT-1:0][PIN_W-1:0] mode_q, dir_q, drv_q, dout_q, din_v;

  cfg_io_decode u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .kind   (kind),
    .port   (port),
    .hit    (hit),
    .wr_sel (wr_sel)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [PIN_W-1:0] LMASK = lane_width_mask(p);

    cfg_io_port_regs #(
      .PIN_W    (PIN_W),
      .PIN_MASK (LMASK),
      .HAS_MODE (MODE_PORTS[p])
    ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wdata   (bus_wdata),
      .wr_mode (wr_sel[int'(K_MODE)*NPORT+p]),
      .wr_dir  (wr_sel[int'(K_DIR)*NPORT+p]),
      .wr_drv  (wr_sel[int'(K_DRV)*NPORT+p]),
      .wr_dout (wr_sel[int'(K_DOUT)*NPORT+p]),
      .mode_q  (mode_q[p]),
      .dir_q   (dir_q[p]),
      .drv_q   (drv_q[p]),
      .dout_q  (dout_q[p])
    );

    cfg_io_pin_path #(
      .PIN_W    (PIN_W),
      .PIN_MASK (LMASK),
      .HAS_PT   (PT_PORTS[p]),
      .SLEW_DRV (SLEW_PORTS[p])
    ) u_path (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_q   (mode_q[p]),
      .dir_q    (dir_q[p]),
      .drv_q    (drv_q[p]),
      .dout_q   (dout_q[p]),
      .ext_addr (ext_addr[p*PIN_W +: PIN_W]),
      .pt_oe    (pt_oe[p*PIN_W +: PIN_W]),
      .pad_out  (pad_out[p*PIN_W +: PIN_W]),
      .pad_oe   (pad_oe[p*PIN_W +: PIN_W]),
      .pad_od   (pad_od[p*PIN_W +: PIN_W]),
      .pad_fast (pad_fast[p*PIN_W +: PIN_W])
    );

    assign din_v[p] = pad_in[p*PIN_W +: PIN_W] & LMASK;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (kind)
        K_MODE:  bus_rdata = mode_q[port];
        K_DIR:   bus_rdata = dir_q[port];
        K_DRV:   bus_rdata = drv_q[port];
        K_DOUT:  bus_rdata = dout_q[port];
        K_DIN:   bus_rdata = din_v[port];
        default: bus_rdata = '0;
      endcase
    end
  end

  // R13
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> bus_rdata == '0);

  // R8
  narrow_pt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    PT_PORTS[NARROW_P] || (pad_oe[NARROW_P*PIN_W +: PIN_W] == (dir_q[NARROW_P] & ~pad_od[NARROW_P*PIN_W +: PIN_W]) ) ||
    (pad_od[NARROW_P*PIN_W +: PIN_W] != '0));
endmodule

// File: tb/cfg_io_bank_test.sv
`timescale 1ns/1ps
module cfg_io_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [31:0] pad_in = '0, ext_addr = '0, pt_oe = '0;
  logic [31:0] pad_out, pad_oe, pad_od, pad_fast;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  cfg_io_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .ext_addr(ext_addr), .pt_oe(pt_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_od(pad_od), .pad_fast(pad_fast)
  );

  // {address, write data, expected readback}
  localparam logic [23:0] VEC [9] = '{
    {8'h04, 8'hA5, 8'hA5},   // R2 dir A
    {8'h09, 8'h3C, 8'h3C},   // R2 drive B
    {8'h02, 8'hFF, 8'h00},   // R5 mode C absent
    {8'h07, 8'hFF, 8'h07},   // R9 dir D narrow
    {8'h0F, 8'hFE, 8'h06},   // R9 data-out D narrow
    {8'h01, 8'h81, 8'h81},   // R2 mode B
    {8'h0E, 8'h5A, 8'h5A},   // R2 data-out C
    {8'h10, 8'hFF, 8'h00},   // R12 data-in A follows pad_in (0)
    {8'h15, 8'hFF, 8'h00}    // R13 unmapped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    bus_wr = 1'b0;
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    logic [7:0] r;
    logic       all_zero;
    do_reset();

    // R1 reset state of every register and pad flag
    all_zero = 1'b1;
    for (int a = 0; a < 16; a++) begin
      rd(5'(a), r);
      if (r != 8'h00) all_zero = 1'b0;
    end
    chk("R1 registers zero", {31'd0, all_zero}, 32'd1);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_od|pad_fast", pad_od | pad_fast, 32'h0);

    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][20:16], VEC[i][15:8]);
      rd(VEC[i][20:16], r);
      chk($sformatf("R2/R5/R9/R12/R13 vector %0d", i), {24'd0, r}, {24'd0, VEC[i][7:0]});
    end

    do_reset();
    // R3 R6 single bit
    wr(5'h04, 8'h01);
    wr(5'h0C, 8'h01);
    settle();
    chk("R3 R6 pad_oe A", pad_oe, 32'h0000_0001);
    chk("R3 pad_out A", pad_out, 32'h0000_0001);

    // R4 address mode on low nibble of A
    ext_addr[7:0] = 8'hC3;
    wr(5'h00, 8'h0F);
    wr(5'h0C, 8'h3C);
    wr(5'h04, 8'hFF);
    settle();
    chk("R4 pad_out A", {24'd0, pad_out[7:0]}, 32'h33);

    // R5 port C has no mode register
    ext_addr[23:16] = 8'hFF;
    wr(5'h02, 8'hFF);
    wr(5'h0E, 8'h00);
    wr(5'h06, 8'hFF);
    settle();
    chk("R5 pad_out C", {24'd0, pad_out[23:16]}, 32'h00);
    chk("R6 pad_oe C", {24'd0, pad_oe[23:16]}, 32'hFF);

    // R7 product term forces output on B
    pt_oe[15:8] = 8'hF0;
    settle();
    chk("R7 pad_oe B", {24'd0, pad_oe[15:8]}, 32'hF0);

    // R8 port D ignores product term
    pt_oe[31:24] = 8'hFF;
    settle();
    chk("R8 pad_oe D", {24'd0, pad_oe[31:24]}, 32'h00);

    // R9 narrow port D pads
    wr(5'h07, 8'hFF);
    wr(5'h0F, 8'hFF);
    settle();
    chk("R9 pad_oe D", {24'd0, pad_oe[31:24]}, 32'h07);
    chk("R9 pad_out D", {24'd0, pad_out[31:24]}, 32'h07);

    // R10 open drain on A
    wr(5'h00, 8'h00);
    wr(5'h08, 8'hFF);
    wr(5'h0C, 8'h0F);
    settle();
    chk("R10 pad_oe A", {24'd0, pad_oe[7:0]}, 32'hF0);
    chk("R10 pad_out A", {24'd0, pad_out[7:0]}, 32'h00);
    chk("R10 pad_od A", {24'd0, pad_od[7:0]}, 32'hFF);

    // R11 slew on C and D
    wr(5'h0A, 8'h81);
    wr(5'h0B, 8'hFF);
    settle();
    chk("R11 pad_fast C", {24'd0, pad_fast[23:16]}, 32'h81);
    chk("R11 pad_fast D", {24'd0, pad_fast[31:24]}, 32'h07);
    chk("R11 pad_od C/D", {16'd0, pad_od[31:16]}, 32'h0);

    // R12 data-in in any mode
    pad_in = 32'hFFFF_FFFF;
    wr(5'h01, 8'hFF);
    rd(5'h13, r);
    chk("R12 din D", {24'd0, r}, 32'h07);
    rd(5'h11, r);
    chk("R12 din B in address mode", {24'd0, r}, 32'hFF);
    pad_in = 32'h1234_5678;
    rd(5'h12, r);
    chk("R12 din C", {24'd0, r}, 32'h34);

    // R13 writes to read-only and unmapped addresses change nothing
    wr(5'h10, 8'h00);
    wr(5'h1F, 8'h00);
    rd(5'h04, r);
    chk("R13 dir A kept", {24'd0, r}, 32'hFF);
    rd(5'h1F, r);
    chk("R13 unmapped read", {24'd0, r}, 32'h00);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule